// File: doc/BRIEF.md
# Asynchronous SRAM controller

This block sits between a clocked host and an external asynchronous static RAM with 17 address lines and an 8-bit data bus. The host presents one request at a time on a valid/ready port: an address, a write byte and a read/write flag. The controller turns each request into a fixed sequence of pin states: an active-low select, an active-high select, an active-low output enable, an active-low write enable, the address lines and a split data bus. The split data bus has an output value, an output-enable for the pad driver and an input value. Read data returns on a one-cycle valid strobe.

All timing is counted in clock periods. `T_RD` sets the read access wait, `T_WP` the write-enable low pulse, `T_DSU` the data setup ahead of the write-enable rising edge, and `T_TURN` the bus turnaround after a read. Each value is rounded up from the RAM's nanosecond figure and is at least 1. A request passes through a setup cycle, an access phase, a recover cycle and, after a read, a turnaround phase, and then returns to idle. The address moves only while both selects are inactive. The output enable stays high for the whole of a write, so the write pulse never has to cover the time the RAM takes to release the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, memSelN=1, memSel=0, memOeN=1, memWeN=1, memDqOe=0 and reqReady=1.
- R2: A request is taken on a rising edge where reqValid and reqReady are both 1. reqReady is 0 from the next cycle until the sequence ends, and it is 1 only while the RAM is deselected (memSelN=1, memSel=0).
- R3: memAddr changes only on the edge that takes a request, when the RAM was deselected. It holds its value for every cycle in which the RAM is selected.
- R4: A write is one setup cycle with memWeN=1, then memWeN=0 for WR_LEN=max(T_WP,T_DSU) cycles, then one recover cycle with memWeN=1 and address and data held. reqReady is 0 for 2+WR_LEN cycles.
- R5: Throughout a write, memOeN stays 1. memDqOe is 1 only from the setup cycle through the recover cycle of a write, and the written byte is stable on memDqOut for at least T_DSU cycles before memWeN rises.
- R6: A read holds memOeN=0 for the setup cycle and T_RD access cycles. The bus is captured at the end of the last access cycle. rspValid is 1 for exactly the following cycle, which is cycle 2+T_RD after acceptance, and rspRdata carries the byte.
- R7: After a read, the selects drop and T_TURN more idle cycles pass before reqReady returns, so reqReady is 0 for 2+T_RD+T_TURN cycles. memDqOe is never 1 while memOeN is 0.
- R8: A read returns the byte most recently written to that address, including at address 0 and address 2^17-1.
- R9: Writes never raise rspValid. Exactly one rspValid pulse is produced per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle, can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Request address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle read data strobe |
| rspRdata | output | 8 | Read byte |
| memAddr | output | 17 | RAM address lines |
| memSelN | output | 1 | RAM select, active low |
| memSel | output | 1 | RAM select, active high |
| memOeN | output | 1 | RAM output enable, active low |
| memWeN | output | 1 | RAM write enable, active low |
| memDqOut | output | 8 | Byte driven onto the data bus |
| memDqOe | output | 1 | Data pad driver enable |
| memDqIn | input | 8 | Byte seen on the data bus |

## Verification
A sequencer stuck in, or skipping, a phase shows up at once as a wrong busy length on reqReady, which the bench measures on every request. A corrupted write flag or counter shows up within the same request: a pulse that is too short, output enable low during a write, contention on the bus, or rspValid in the wrong cycle. The RAM model catches each of these on the falling edge where it happens. A capture that comes too early returns the model's filler byte, and the scoreboard reports it when that read completes.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_RECOVER,
    ST_TURN
  } seq_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;  // latch request fields
    logic select;   // both RAM selects active
    logic outEn;    // RAM output enable active
    logic wrPulse;  // write enable active
    logic drive;    // controller drives data bus
    logic sample;   // capture RAM read data
  } strobes_t;

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int T_RD   = 4,
  parameter int T_WP   = 3,
  parameter int T_DSU  = 2,
  parameter int T_TURN = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output strobes_t stb
);

  localparam int WR_LEN  = (T_WP >= T_DSU) ? T_WP : T_DSU;
  localparam int MAX_A   = (WR_LEN >= T_RD) ? WR_LEN : T_RD;
  localparam int MAX_LEN = (MAX_A >= T_TURN) ? MAX_A : T_TURN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  seq_state_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic isWrite;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE:
        if (reqValid) nextState = ST_SETUP;
      ST_SETUP: begin
        nextCnt   = isWrite ? CNT_W'(WR_LEN - 1) : CNT_W'(T_RD - 1);
        nextState = ST_ACCESS;
      end
      ST_ACCESS:
        if (cnt == '0) nextState = ST_RECOVER;
        else           nextCnt   = cnt - 1'b1;
      ST_RECOVER:
        if (isWrite) nextState = ST_IDLE;
        else begin
          nextCnt   = CNT_W'(T_TURN - 1);
          nextState = ST_TURN;
        end
      ST_TURN:
        if (cnt == '0) nextState = ST_IDLE;
        else           nextCnt   = cnt - 1'b1;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      isWrite <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      if (state == ST_IDLE && reqValid) isWrite <= reqWrite;
    end
  end

  logic active;
  assign active   = (state == ST_SETUP) || (state == ST_ACCESS) || (state == ST_RECOVER);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stb.capture = (state == ST_IDLE) && reqValid;
    stb.select  = active;
    stb.outEn   = !isWrite && ((state == ST_SETUP) || (state == ST_ACCESS));
    stb.wrPulse = isWrite && (state == ST_ACCESS);
    stb.drive   = isWrite && active;
    stb.sample  = !isWrite && (state == ST_ACCESS) && (cnt == '0);
  end

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSel,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              rspQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      if (stb.capture) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (stb.sample) rdataQ <= memDqIn;
      rspQ <= stb.sample;
    end
  end

  assign memAddr  = addrQ;
  assign memSelN  = !stb.select;
  assign memSel   = stb.select;
  assign memOeN   = !stb.outEn;
  assign memWeN   = !stb.wrPulse;
  assign memDqOut = wdataQ;
  assign memDqOe  = stb.drive;
  assign rspValid = rspQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int T_RD   = 4,
  parameter int T_WP   = 3,
  parameter int T_DSU  = 2,
  parameter int T_TURN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSel,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobes_t stb;

  asram_ctrl_fsm #(
    .T_RD(T_RD), .T_WP(T_WP), .T_DSU(T_DSU), .T_TURN(T_TURN)
  ) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  asram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memSelN(memSelN), .memSel(memSel), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int T_WP   = 3,
  parameter int T_DSU  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memSelN,
  input logic              memSel,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDqOe
);

  localparam int WR_LEN = (T_WP >= T_DSU) ? T_WP : T_DSU;

  logic [15:0] weLowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        weLowCnt <= '0;
    else if (!memWeN) weLowCnt <= weLowCnt + 1'b1;
    else              weLowCnt <= '0;
  end

  assert_ready_deselected_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memSelN && !memSel && memWeN && !memDqOe));

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!memSelN && $past(!memSelN)) |-> $stable(memAddr));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= 16'(WR_LEN)));

  assert_write_oe_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memSelN && memSel && memDqOe));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |-> $past(!memOeN));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .T_WP(T_WP), .T_DSU(T_DSU)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .memAddr(memAddr), .memSelN(memSelN), .memSel(memSel),
  .memOeN(memOeN), .memWeN(memWeN), .memDqOe(memDqOe)
);

// File: tb/asram_ctrl_tb_top.sv
module asram_ctrl_tb_top;

  localparam int T_RD   = 4;
  localparam int T_WP   = 3;
  localparam int T_DSU  = 2;
  localparam int T_TURN = 2;
  localparam int WR_LEN = (T_WP >= T_DSU) ? T_WP : T_DSU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic reqReady, rspValid;
  logic [7:0] rspRdata;
  logic [16:0] memAddr;
  logic memSelN, memSel, memOeN, memWeN, memDqOe;
  logic [7:0] memDqOut, memDqIn;

  always #5 clk = !clk;

  asram_ctrl #(.T_RD(T_RD), .T_WP(T_WP), .T_DSU(T_DSU), .T_TURN(T_TURN)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memSelN(memSelN), .memSel(memSel), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural RAM model ----------------
  logic [7:0] mem [int];
  logic ramDrv = 1'b0;
  logic [7:0] ramQ = 8'h00;
  logic prevSel = 1'b0, prevWeN = 1'b1, prevReading = 1'b0, prevDqOe = 1'b0;
  logic [16:0] prevAddr = '0;
  logic [7:0]  prevDq = '0;
  int weLowCnt = 0, rdCnt = 0, quietCnt = 255, dqStable = 0;
  bit everRead = 1'b0;

  assign memDqIn = ramDrv ? ramQ : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      automatic logic selNow  = !memSelN && memSel;
      automatic logic reading = selNow && !memOeN && memWeN;
      if (prevSel && memAddr != prevAddr)
        check(1'b0, "R3", "address moved while selected", int'(memAddr), int'(prevAddr));
      if (!memWeN && !memOeN)
        check(1'b0, "R5", "output enable low during write", 0, 1);
      if (memDqOe && memDqOut == prevDq && prevDqOe) dqStable++;
      else if (memDqOe) dqStable = 1;
      else dqStable = 0;
      if (!memWeN) weLowCnt++;
      else if (!prevWeN) begin
        check(weLowCnt >= T_WP, "R4", "write pulse cycles", weLowCnt, T_WP);
        check(dqStable >= T_DSU + 1, "R5", "data stable cycles at write end", dqStable, T_DSU + 1);
        mem[int'(prevAddr)] = prevDq;
        weLowCnt = 0;
      end
      if (reading && prevReading && memAddr == prevAddr) rdCnt++;
      else rdCnt = reading ? 1 : 0;
      ramDrv = reading;
      ramQ   = (rdCnt >= T_RD + 1) ?
               (mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 8'h00) : 8'hEE;
      if (reading) everRead = 1'b1;
      if (ramDrv && memDqOe)
        check(1'b0, "R7", "bus contention", 1, 0);
      if (ramDrv) quietCnt = 0;
      else if (quietCnt < 255) quietCnt++;
      if (memDqOe && !prevDqOe && everRead)
        check(quietCnt >= T_TURN + 1, "R7", "quiet cycles before driving", quietCnt, T_TURN + 1);
      prevSel = selNow; prevWeN = memWeN; prevReading = reading;
      prevAddr = memAddr; prevDq = memDqOut; prevDqOe = memDqOe;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] expQ [$];
  logic [7:0] shadow [int];

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) check(1'b0, "R9", "unexpected read response", 1, 0);
      else begin
        automatic logic [7:0] e = expQ.pop_front();
        check(rspRdata == e, "R8", "read data", int'(rspRdata), int'(e));
      end
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int busy = 0;
    int rspAt = -1;
    if (wr) shadow[int'(a)] = d;
    else expQ.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R2", "ready low after accept", int'(reqReady), 0);
    while (!reqReady) begin
      busy++;
      if (rspValid) rspAt = busy;
      @(negedge clk);
    end
    if (wr) begin
      check(busy == 2 + WR_LEN, "R4", "write busy cycles", busy, 2 + WR_LEN);
      check(rspAt == -1, "R9", "response after write", rspAt, -1);
    end else begin
      check(busy == 2 + T_RD + T_TURN, "R7", "read busy cycles", busy, 2 + T_RD + T_TURN);
      check(rspAt == 2 + T_RD, "R6", "response cycle", rspAt, 2 + T_RD);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady && memSelN && !memSel && memOeN && memWeN && !memDqOe, "R1",
          "pins in reset", {memSelN, memSel, memOeN, memWeN, memDqOe, reqReady}, 6'b101101);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && memSelN && !memSel && memOeN && memWeN && !memDqOe, "R1",
          "pins idle after reset", {memSelN, memSel, memOeN, memWeN, memDqOe, reqReady}, 6'b101101);
    issue(1'b1, 17'h00000, 8'hA5);
    issue(1'b1, 17'h1FFFF, 8'h5A);
    issue(1'b0, 17'h00000, 8'h00);
    issue(1'b0, 17'h1FFFF, 8'h00);
    issue(1'b1, 17'h00000, 8'hFF);
    issue(1'b1, 17'h0ABCD, 8'h00);
    issue(1'b0, 17'h00000, 8'h00);
    issue(1'b0, 17'h0ABCD, 8'h00);
    issue(1'b0, 17'h01234, 8'h00);
    for (int i = 0; i < 8; i++) issue(1'b1, 17'(i * 4099), 8'(8'h11 * i + 3));
    for (int i = 0; i < 8; i++) issue(1'b0, 17'(i * 4099), 8'h00);
    repeat (4) @(negedge clk);
    check(reqReady && memSelN && !memSel && memOeN && memWeN && !memDqOe, "R1",
          "pins idle at end", {memSelN, memSel, memOeN, memWeN, memDqOe, reqReady}, 6'b101101);
    check(expQ.size() == 0, "R9", "responses outstanding", expQ.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule